// File: doc/BRIEF.md
# Floating-Point Operand NaN and Denormal Conditioner

This block sits in front of a floating-point execution unit and prepares up to two operands before any arithmetic happens. Each operand can be half, single, double or bfloat16. The block flushes denormal inputs to signed zero when the control bits call for it. It also decides whether the operation collapses to a NaN result. When it does, the block supplies that NaN so the datapath can bypass its arithmetic. It also raises the invalid-operation and input-denormal events that the operands cause.

Five control bits steer the behaviour:
- Default-NaN makes every NaN result the canonical NaN.
- Flush-to-zero is the main flush control. It acts on single and double only.
- Half flush-to-zero is the flush control for half precision.
- Flush-inputs flushes single, double and bfloat16 inputs.
- Alternate-handling sets the sign of the default NaN to 1. It also selects two-NaN results by operand position only and changes when input-denormal events are raised.

An operation-class tag marks three kinds of operation: ordinary arithmetic, sign-only operations (abs or negate), and min/max. Results are registered, so they appear one cycle after the inputs.

Top module: `fpp_operand_cond`

## Requirements
- R1: Every output is registered. `valid_o` equals `valid_i` of the previous cycle. A result appears in the cycle after its inputs, and the three flags are 0 whenever `valid_o` is 0. Reset clears `valid_o`, the flags and the data outputs.
- R2: The format encoding is 0 for half (1/5/10 bits), 1 for single (1/8/23), 2 for double (1/11/52) and 3 for bfloat16 (1/8/7). The value sits in the low bits of each operand port. Input bits above the format width are ignored, and every data output is zero above the format width.
- R3: When default-NaN is 1 and any considered operand is a NaN, `nan_hit_o` is 1. `nan_res_o` is then the default NaN: exponent all ones, only the top fraction bit set, and a sign equal to alternate-handling. The exception is a min/max operation with alternate-handling 1.
- R4: In every case not covered by R3 or R5, a NaN result comes from the first operand that is a signaling NaN. If neither is signaling, it comes from the first operand that is a NaN. Operand a counts as first. The chosen NaN is quieted by setting its top fraction bit.
- R5: When alternate-handling is 1, default-NaN is 0 and the operation is not min/max, two NaN operands give the quieted operand a. This holds whichever of the two is signaling.
- R6: `inv_o` is 1 exactly when a considered operand is a signaling NaN. A signaling NaN is exponent all ones, fraction nonzero and top fraction bit 0.
- R7: A single, double or bfloat16 denormal is replaced by a zero that keeps its sign when flush-inputs is 1. A single or double denormal is also replaced when flush-to-zero is 1 and alternate-handling is 0.
- R8: A half denormal is flushed only by half flush-to-zero, and flush-to-zero has no effect on half. Half and bfloat16 operands never raise `idn_o`.
- R9: A considered single or double denormal raises `idn_o` in two cases. The first is alternate-handling 0 with flush-to-zero 1. The second is alternate-handling 1 with flush-inputs 0. In any other case it does not raise `idn_o`.
- R10: The operation class is 0 for arithmetic, 1 for sign-only and 2 for min/max; class 3 acts as arithmetic. For class 1 the operands pass unflushed, and `nan_hit_o`, `inv_o` and `idn_o` stay 0.
- R11: With `dual_i` 0, operand b takes no part in the NaN choice, `inv_o` or `idn_o`. It is still conditioned onto `opb_o`.
- R12: For a min/max operation with alternate-handling 1, default-NaN is ignored. A NaN result then follows the R4 priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs are valid this cycle |
| fmt_i | input | 2 | Operand format |
| op_i | input | 2 | Operation class |
| dual_i | input | 1 | Operand b is used |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| dn_i | input | 1 | Default-NaN control |
| fz_i | input | 1 | Main flush-to-zero control |
| fz16_i | input | 1 | Half-precision flush-to-zero control |
| fiz_i | input | 1 | Flush-inputs control |
| ah_i | input | 1 | Alternate-handling control |
| valid_o | output | 1 | Registered valid |
| opa_o | output | 64 | Conditioned operand a |
| opb_o | output | 64 | Conditioned operand b |
| nan_hit_o | output | 1 | Result is a NaN and the arithmetic is bypassed |
| nan_res_o | output | 64 | NaN result value, zero when no hit |
| inv_o | output | 1 | Invalid-operation event |
| idn_o | output | 1 | Input-denormal event |

## Verification
The bench uses the only configuration there is: a 64-bit operand container holding the four formats. It builds that configuration and sweeps it almost exhaustively. Every format is crossed with all 32 control combinations, the three operation classes and both operand counts. Operand a and operand b are each drawn from seven classes: zero, small denormal, full denormal, normal with junk above the format width, infinity, quiet NaN and signaling NaN. This reaches every NaN priority pairing, every flush and event case, and the single-operand masking.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {FMT_H = 2'd0, FMT_S = 2'd1, FMT_D = 2'd2, FMT_B = 2'd3} fmt_e;
  typedef enum logic [1:0] {OP_ARITH = 2'd0, OP_SIGN = 2'd1, OP_MINMAX = 2'd2, OP_RSVD = 2'd3} opc_e;

  typedef struct packed {
    logic dn;
    logic fz;
    logic fz16;
    logic fiz;
    logic ah;
  } ctl_t;

  typedef struct packed {
    logic             nan;
    logic             snan;
    logic             sub;
    logic [XLEN-1:0]  raw;
    logic [XLEN-1:0]  zero;
    logic [XLEN-1:0]  quiet;
  } opnd_t;

  function automatic logic [XLEN-1:0] sgn_mask(fmt_e f);
    case (f)
      FMT_S:   return 64'h0000_0000_8000_0000;
      FMT_D:   return 64'h8000_0000_0000_0000;
      default: return 64'h0000_0000_0000_8000;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_mask(fmt_e f);
    case (f)
      FMT_H:   return 64'h0000_0000_0000_7C00;
      FMT_S:   return 64'h0000_0000_7F80_0000;
      FMT_D:   return 64'h7FF0_0000_0000_0000;
      default: return 64'h0000_0000_0000_7F80;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] frac_mask(fmt_e f);
    case (f)
      FMT_H:   return 64'h0000_0000_0000_03FF;
      FMT_S:   return 64'h0000_0000_007F_FFFF;
      FMT_D:   return 64'h000F_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_0000_007F;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] qbit_mask(fmt_e f);
    case (f)
      FMT_H:   return 64'h0000_0000_0000_0200;
      FMT_S:   return 64'h0000_0000_0040_0000;
      FMT_D:   return 64'h0008_0000_0000_0000;
      default: return 64'h0000_0000_0000_0040;
    endcase
  endfunction
endpackage

// File: rtl/fpp_classify.sv
module fpp_classify
  import fpp_pkg::*;
(
  input  fmt_e            fmt_i,
  input  logic [XLEN-1:0] val_i,
  output opnd_t           info_o
);
  logic [XLEN-1:0] sm, em, fm, qm, v;
  logic exp_ones, exp_zero, frac_nz, q_set;

  always_comb begin
    sm = sgn_mask(fmt_i);
    em = exp_mask(fmt_i);
    fm = frac_mask(fmt_i);
    qm = qbit_mask(fmt_i);
    v  = val_i & (sm | em | fm);  // drop bits above the format
    exp_ones = (v & em) == em;
    exp_zero = (v & em) == '0;
    frac_nz  = (v & fm) != '0;
    q_set    = (v & qm) != '0;
    info_o.nan   = exp_ones & frac_nz;
    info_o.snan  = exp_ones & frac_nz & ~q_set;
    info_o.sub   = exp_zero & frac_nz;
    info_o.raw   = v;
    info_o.zero  = v & sm;
    info_o.quiet = v | qm;
  end
endmodule

// File: rtl/fpp_flush.sv
module fpp_flush
  import fpp_pkg::*;
(
  input  fmt_e            fmt_i,
  input  opc_e            op_i,
  input  ctl_t            ctl_i,
  input  opnd_t           info_i,
  output logic [XLEN-1:0] val_o,
  output logic            idn_o
);
  logic exempt, sd, flush;

  always_comb begin
    exempt = (op_i == OP_SIGN);
    sd     = (fmt_i == FMT_S) || (fmt_i == FMT_D);
    case (fmt_i)
      FMT_H:   flush = ctl_i.fz16;
      FMT_B:   flush = ctl_i.fiz;
      default: flush = ctl_i.fiz | (ctl_i.fz & ~ctl_i.ah);
    endcase
    flush = flush & info_i.sub & ~exempt;
    val_o = flush ? info_i.zero : info_i.raw;
    idn_o = info_i.sub & ~exempt & sd &
            ((~ctl_i.ah & ctl_i.fz) | (ctl_i.ah & ~ctl_i.fiz));
  end
endmodule

// File: rtl/fpp_nan_pick.sv
module fpp_nan_pick
  import fpp_pkg::*;
(
  input  fmt_e            fmt_i,
  input  opc_e            op_i,
  input  ctl_t            ctl_i,
  input  logic            dual_i,
  input  opnd_t           a_i,
  input  opnd_t           b_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o,
  output logic            inv_o
);
  logic act, na, nb, sa, sb, mm, use_dn, take_a;
  logic [XLEN-1:0] dnan;

  always_comb begin
    act = (op_i != OP_SIGN);
    mm  = (op_i == OP_MINMAX);
    na  = a_i.nan;
    nb  = dual_i & b_i.nan;
    sa  = a_i.snan;
    sb  = dual_i & b_i.snan;
    hit_o  = act & (na | nb);
    inv_o  = act & (sa | sb);
    use_dn = ctl_i.dn & ~(ctl_i.ah & mm);
    dnan   = exp_mask(fmt_i) | qbit_mask(fmt_i) | (ctl_i.ah ? sgn_mask(fmt_i) : '0);
    // positional choice under alternate handling, else signaling first then a first
    if (ctl_i.ah && !mm && na && nb) take_a = 1'b1;
    else if (sa)                     take_a = 1'b1;
    else if (sb)                     take_a = 1'b0;
    else                             take_a = na;
    if (!hit_o)      res_o = '0;
    else if (use_dn) res_o = dnan;
    else             res_o = take_a ? a_i.quiet : b_i.quiet;
  end
endmodule

// File: rtl/fpp_operand_cond.sv
module fpp_operand_cond
  import fpp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  op_i,
  input  logic        dual_i,
  input  logic [63:0] opa_i,
  input  logic [63:0] opb_i,
  input  logic        dn_i,
  input  logic        fz_i,
  input  logic        fz16_i,
  input  logic        fiz_i,
  input  logic        ah_i,
  output logic        valid_o,
  output logic [63:0] opa_o,
  output logic [63:0] opb_o,
  output logic        nan_hit_o,
  output logic [63:0] nan_res_o,
  output logic        inv_o,
  output logic        idn_o
);
  localparam int NOPS = 2;

  fmt_e fmt;
  opc_e opc;
  ctl_t ctl;
  assign fmt = fmt_e'(fmt_i);
  assign opc = opc_e'(op_i);
  assign ctl = '{dn: dn_i, fz: fz_i, fz16: fz16_i, fiz: fiz_i, ah: ah_i};

  logic [XLEN-1:0] src  [NOPS];
  logic [XLEN-1:0] cond [NOPS];
  opnd_t           info [NOPS];
  logic [NOPS-1:0] idn_v;
  logic [NOPS-1:0] use_v;
  assign src[0] = opa_i;
  assign src[1] = opb_i;
  assign use_v  = {dual_i, 1'b1};

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fpp_classify u_cls (
      .fmt_i (fmt),
      .val_i (src[g]),
      .info_o(info[g])
    );
    fpp_flush u_fl (
      .fmt_i (fmt),
      .op_i  (opc),
      .ctl_i (ctl),
      .info_i(info[g]),
      .val_o (cond[g]),
      .idn_o (idn_v[g])
    );
  end

  logic            hit_c, inv_c;
  logic [XLEN-1:0] res_c;

  fpp_nan_pick u_pick (
    .fmt_i (fmt),
    .op_i  (opc),
    .ctl_i (ctl),
    .dual_i(dual_i),
    .a_i   (info[0]),
    .b_i   (info[1]),
    .hit_o (hit_c),
    .res_o (res_c),
    .inv_o (inv_c)
  );

  fmt_e fmt_q;
  opc_e op_q;
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      opa_o     <= '0;
      opb_o     <= '0;
      nan_hit_o <= 1'b0;
      nan_res_o <= '0;
      inv_o     <= 1'b0;
      idn_o     <= 1'b0;
      fmt_q     <= FMT_H;
      op_q      <= OP_ARITH;
      ctl_q     <= '0;
    end else begin
      valid_o   <= valid_i;
      opa_o     <= cond[0];
      opb_o     <= cond[1];
      nan_hit_o <= valid_i & hit_c;
      nan_res_o <= res_c;
      inv_o     <= valid_i & inv_c;
      idn_o     <= valid_i & |(idn_v & use_v);
      fmt_q     <= fmt;
      op_q      <= opc;
      ctl_q     <= ctl;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_flags_need_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(nan_hit_o || inv_o || idn_o));
  assert_nan_is_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_hit_o |-> ((nan_res_o & exp_mask(fmt_q)) == exp_mask(fmt_q)) &&
                  ((nan_res_o & qbit_mask(fmt_q)) != '0));
  assert_dnan_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nan_hit_o && ctl_q.dn && op_q != OP_MINMAX |->
      (((nan_res_o & sgn_mask(fmt_q)) != '0) == ctl_q.ah));
  assert_inv_needs_nan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> nan_hit_o);
  assert_no_idn_narrow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (fmt_q == FMT_H || fmt_q == FMT_B) |-> !idn_o);
  assert_sign_op_passive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && op_q == OP_SIGN |-> !nan_hit_o && !inv_o && !idn_o);
endmodule

// File: tb/fpp_operand_cond_bench.sv
module fpp_operand_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  fmt_i = '0;
  logic [1:0]  op_i = '0;
  logic        dual_i = 1'b0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic        dn_i = 1'b0, fz_i = 1'b0, fz16_i = 1'b0, fiz_i = 1'b0, ah_i = 1'b0;
  logic        valid_o, nan_hit_o, inv_o, idn_o;
  logic [63:0] opa_o, opb_o, nan_res_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fpp_operand_cond u_fpp_operand_cond (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fmt_i(fmt_i), .op_i(op_i),
    .dual_i(dual_i), .opa_i(opa_i), .opb_i(opb_i), .dn_i(dn_i), .fz_i(fz_i),
    .fz16_i(fz16_i), .fiz_i(fiz_i), .ah_i(ah_i), .valid_o(valid_o), .opa_o(opa_o),
    .opb_o(opb_o), .nan_hit_o(nan_hit_o), .nan_res_o(nan_res_o), .inv_o(inv_o),
    .idn_o(idn_o)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp_v);
    end
  endtask

  function automatic int fw_of(input int f);
    case (f) 0: return 10; 1: return 23; 2: return 52; default: return 7; endcase
  endfunction
  function automatic int ew_of(input int f);
    case (f) 0: return 5; 2: return 11; default: return 8; endcase
  endfunction
  function automatic logic [63:0] lowmask(input int n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  // fields: sign s, biased exponent e, fraction fr, junk above width
  function automatic logic [63:0] build(input int f, input int s, input logic [63:0] e,
                                        input logic [63:0] fr, input logic junk);
    int fw = fw_of(f);
    int w  = 1 + ew_of(f) + fw;
    logic [63:0] x = (64'(s) << (w - 1)) | (e << fw) | fr;
    if (junk && w < 64) x = x | (64'hA5A5_5A5A_C3C3_3C3C & ~lowmask(w));
    return x;
  endfunction

  function automatic logic [63:0] sample(input int f, input int k);
    int fw = fw_of(f);
    logic [63:0] eo = lowmask(ew_of(f));
    case (k)
      0: return build(f, 0, 0, 0, 1'b0);
      1: return build(f, 1, 0, 64'd1, 1'b0);
      2: return build(f, 0, 0, lowmask(fw), 1'b0);
      3: return build(f, 1, 64'd1, 64'd5, 1'b1);               // R2 junk above width
      4: return build(f, 0, eo, 0, 1'b0);
      5: return build(f, 1, eo, (64'd1 << (fw - 1)) | 64'd1, 1'b0);
      default: return build(f, 0, eo, 64'd2, 1'b0);
    endcase
  endfunction

  function automatic logic [63:0] clean(input int f, input logic [63:0] x);
    return x & lowmask(1 + ew_of(f) + fw_of(f));
  endfunction
  function automatic logic [63:0] expo(input int f, input logic [63:0] x);
    return (x >> fw_of(f)) & lowmask(ew_of(f));
  endfunction
  function automatic logic [63:0] frac(input int f, input logic [63:0] x);
    return x & lowmask(fw_of(f));
  endfunction
  function automatic logic is_nan(input int f, input logic [63:0] x);
    return expo(f, x) == lowmask(ew_of(f)) && frac(f, x) != 0;
  endfunction
  function automatic logic is_snan(input int f, input logic [63:0] x);
    return is_nan(f, x) && !frac(f, x)[fw_of(f) - 1];
  endfunction
  function automatic logic is_sub(input int f, input logic [63:0] x);
    return expo(f, x) == 0 && frac(f, x) != 0;
  endfunction
  function automatic logic [63:0] quieten(input int f, input logic [63:0] x);
    return clean(f, x) | (64'd1 << (fw_of(f) - 1));
  endfunction

  task automatic cond_model(input int f, input int op, input logic [4:0] c,
                            input logic [63:0] x, output logic [63:0] y, output logic id);
    logic dn = c[4], fz = c[3], fz16 = c[2], fiz = c[1], ah = c[0];
    logic fl = 1'b0;
    id = 1'b0;
    if (op != 1 && is_sub(f, x)) begin
      if (f == 0)      fl = fz16;                          // R8
      else if (f == 3) fl = fiz;                           // R7
      else begin
        fl = fiz || (fz && !ah);                           // R7
        id = (!ah && fz) || (ah && !fiz);                  // R9
      end
    end
    if (dn) y = clean(f, x); // keep dn referenced
    y = fl ? (clean(f, x) & (64'd1 << (ew_of(f) + fw_of(f)))) : clean(f, x);
  endtask

  initial begin
    logic [63:0] a, b, ea, eb, er;
    logic ida, idb, eh, ei, ed, na, nb, sa, sb, usedn, pa;
    logic [4:0] c;
    string ta, tn;
    #1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "valid_o", 64'(valid_o), 64'd0);
    chk("R1", "nan_hit_o", 64'(nan_hit_o), 64'd0);
    chk("R1", "inv_o", 64'(inv_o), 64'd0);
    chk("R1", "idn_o", 64'(idn_o), 64'd0);
    chk("R1", "opa_o", opa_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 4; f++)
      for (int op = 0; op < 3; op++)
        for (int cc = 0; cc < 32; cc++)
          for (int two = 0; two < 2; two++)
            for (int ka = 0; ka < 7; ka++)
              for (int kb = 0; kb < 7; kb++) begin
                c = 5'(cc);
                a = sample(f, ka);
                b = sample(f, kb);
                valid_i = 1'b1; fmt_i = 2'(f); op_i = 2'(op); dual_i = (two != 0);
                opa_i = a; opb_i = b;
                {dn_i, fz_i, fz16_i, fiz_i, ah_i} = c;
                cond_model(f, op, c, a, ea, ida);
                cond_model(f, op, c, b, eb, idb);
                na = is_nan(f, a); nb = (two != 0) && is_nan(f, b);
                sa = is_snan(f, a); sb = (two != 0) && is_snan(f, b);
                eh = (op != 1) && (na || nb);
                ei = (op != 1) && (sa || sb);                // R6
                ed = ida || ((two != 0) && idb);
                usedn = c[4] && !(c[0] && op == 2);          // R3, R12
                if (c[0] && op != 2 && na && nb) pa = 1'b1;  // R5
                else if (sa) pa = 1'b1;                      // R4
                else if (sb) pa = 1'b0;
                else pa = na;
                if (!eh) er = 0;
                else if (usedn)
                  er = (lowmask(ew_of(f)) << fw_of(f)) | (64'd1 << (fw_of(f) - 1)) |
                       (64'(c[0]) << (ew_of(f) + fw_of(f)));
                else er = pa ? quieten(f, a) : quieten(f, b);
                ta = (op == 1) ? "R10" : (f == 0) ? "R8" : (ka == 3) ? "R2" : "R7";
                tn = (op == 2 && c[0]) ? "R12" : c[4] ? "R3" :
                     (c[0] && na && nb) ? "R5" : (two == 0) ? "R11" : "R4";
                @(negedge clk);
                chk(ta, "opa_o", opa_o, ea);
                chk((two == 0) ? "R11" : ta, "opb_o", opb_o, eb);
                chk(tn, "nan_hit_o", 64'(nan_hit_o), 64'(eh));
                chk(tn, "nan_res_o", nan_res_o, er);
                chk((op == 1) ? "R10" : "R6", "inv_o", 64'(inv_o), 64'(ei));
                chk((f == 0 || f == 3) ? "R8" : "R9", "idn_o", 64'(idn_o), 64'(ed));
                chk("R1", "valid_o", 64'(valid_o), 64'd1);
              end
    // R1: flags drop with valid
    valid_i = 1'b0;
    @(negedge clk);
    chk("R1", "valid_o low", 64'(valid_o), 64'd0);
    chk("R1", "flags low", 64'({nan_hit_o, inv_o, idn_o}), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule